// File: doc/BRIEF.md
# Channel Data Loader Sequencer

This block loads a frequency synthesiser's divider settings from a small external memory that is four bits wide. It runs from the reference clock and divides it by 64 to form a program clock. A read addresses eight words in turn, one word per program clock. The block samples each returned nibble late in its word slot and keeps it in an internal store. After the eighth word it builds an 11-bit reference divisor, a 10-bit M count and a 7-bit A count from the stored nibbles. All three values are presented at once, together with a one-cycle load strobe.

There are three ways to start a read. An edge on the program-enable input starts a single read. Holding that input low makes the read repeat every 16 program clocks. After reset, which stands for power-up detection, a read starts by itself once a fixed settling delay has run out. The memory-enable output is active low and is asserted for the whole read, so that the memory can be powered down between reads. The address outputs come with a separate drive enable, so that the address bus can be released when no read is in progress.

Top module: `prom_loader`

## Requirements
- R1: A read drives word addresses 0,1,...,7 on `word_sel` in ascending order. Each address is held for one program clock of 64 reference cycles, and `word_sel_oe` is high only during those eight slots. While `word_sel_oe` is low, `word_sel` reads 0.
- R2: `mem_en_n` is 0 from the first word slot through the transfer slot that follows word 7, and it is 1 whenever the block is idle.
- R3: The nibble for a word is the value of `mem_data` at the clock edge where the 61st reference cycle of that word's slot ends (prescaler count 60). The value of `mem_data` at any other point in the slot has no effect.
- R4: Field map, with word n on bits D3..D0 = `mem_data[3:0]`. m_count[1:0] comes from word 0 bits [3:2]. m_count[5:2] comes from word 1 and m_count[9:6] from word 2. a_count[3:0] comes from word 3 and a_count[6:4] from word 4 bits [2:0]. ref_div[3:0] comes from word 5, ref_div[7:4] from word 6 and ref_div[10:8] from word 7 bits [2:0].
- R5: Word 0 bits [1:0], word 4 bit 3 and word 7 bit 3 have no effect on any output.
- R6: The transfer slot is the program clock that follows word 7. `load_stb` is high for exactly one reference cycle, the 33rd cycle of that slot, which is the first cycle of the program clock's low half. All three fields take their new values in that same cycle and hold them at every other time.
- R7: Outside a read, a rising or falling edge on `prog_en` passes through a two-stage synchroniser. The read then begins at the next program-clock boundary, 3 to 66 reference cycles after the edge.
- R8: An edge on `prog_en` that arrives while a read or transfer is in progress is ignored and does not start a further read.
- R9: If `prog_en` is low at the end of the transfer slot, the block waits the rest of a 16-program-clock cycle and reads again. Loads are then 1024 reference cycles apart, and `mem_en_n` stays 0 for as long as `prog_en` stays low.
- R10: After reset is released, a read starts by itself at the first program-clock boundary on or after 53248 reference cycles. `prog_en` activity before that point is ignored.
- R11: During reset `mem_en_n` is 1, `word_sel_oe` and `load_stb` are 0, and all three fields are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset; release marks power-up |
| prog_en | input | 1 | Program enable: an edge starts one read, a low level repeats reads |
| mem_data | input | 4 | Nibble returned by the external memory, bit 3 most significant |
| word_sel | output | 3 | Word address to the memory |
| word_sel_oe | output | 1 | Drive enable for `word_sel`; low means the bus is released |
| mem_en_n | output | 1 | Memory enable, active low, released high when idle |
| ref_div | output | 11 | Assembled reference divisor |
| m_count | output | 10 | Assembled M count |
| a_count | output | 7 | Assembled A count |
| load_stb | output | 1 | One-cycle strobe marking a new set of fields |

## Verification
Two things can fall in the same cycle. One is a start request arriving exactly on a program-clock boundary: the request comes from a synchronised edge, from a low level, or from the end of the power-up count. The other is the sequencer's own slot-boundary decision, either to end a transfer or to leave the idle state. The bench provokes this by firing single-shot pulses at offsets that step across the 64-cycle prescaler phase, and by pulsing again in the middle of a read. The timing of the memory enable and the address is then judged against a cycle-by-cycle behavioural model on every clock. The bench also toggles the memory data on every cycle during one read. Only the sample point named in R3 can then give the assembled fields the model expects.

// File: rtl/pld_pkg.sv
`timescale 1ns/1ps
// Package: shared constants, sequencer state type and the nibble-to-field map.
// Assumes eight four-bit words per channel, packed word n at bits [4n+3:4n].
package pld_pkg;

    localparam int NIB_W  = 4;
    localparam int WORDS  = 8;
    localparam int SEL_W  = $clog2(WORDS);
    localparam int FLAT_W = WORDS * NIB_W;
    localparam int REF_W  = 11;
    localparam int M_W    = 10;
    localparam int A_W    = 7;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_READ = 2'd1,
        ST_XFER = 2'd2,
        ST_GAP  = 2'd3
    } ldr_state_e;

    typedef struct packed {
        logic [REF_W-1:0] ref_div;
        logic [M_W-1:0]   m_val;
        logic [A_W-1:0]   a_val;
    } chan_fields_t;

    // Gather scattered nibble bits into the three divider fields.
    function automatic chan_fields_t assemble_fields(input logic [FLAT_W-1:0] w);
        chan_fields_t f;
        f.m_val   = {w[11:8], w[7:4], w[3:2]};
        f.a_val   = {w[18:16], w[15:12]};
        f.ref_div = {w[30:28], w[27:24], w[23:20]};
        return f;
    endfunction

endpackage

// File: rtl/pld_timebase.sv
`timescale 1ns/1ps
// Timebase: divides the reference clock into program-clock slots and times
// the power-up delay. Assumes reset release marks supply detection.
// Outputs are single-cycle markers at fixed prescaler counts.
module pld_timebase #(
    parameter int PRESC_BITS     = 6,
    parameter int SAMPLE_POINT   = 60,
    parameter int POWERUP_CYCLES = 53248
) (
    input  logic clk,
    input  logic rst_n,
    output logic slot_end,
    output logic sample_now,
    output logic load_now,
    output logic pwr_fire,
    output logic pwr_ready
);
    localparam int PW = $clog2(POWERUP_CYCLES + 1);
    localparam logic [PRESC_BITS-1:0] C_MAX    = '1;
    localparam logic [PRESC_BITS-1:0] C_SAMPLE = PRESC_BITS'(SAMPLE_POINT);
    localparam logic [PRESC_BITS-1:0] C_LOAD   = C_MAX >> 1;
    localparam logic [PW-1:0]         C_WAIT   = PW'(POWERUP_CYCLES - 1);

    logic [PRESC_BITS-1:0] presc;
    logic [PW-1:0]         wait_cnt;

    // Free-running prescaler: one full wrap is one program clock.
    always_ff @(posedge clk) begin
        if (!rst_n) presc <= '0;
        else        presc <= presc + 1'b1;
    end

    assign slot_end   = (presc == C_MAX);
    assign sample_now = (presc == C_SAMPLE);
    assign load_now   = (presc == C_LOAD);
    assign pwr_fire   = !pwr_ready && (wait_cnt == C_WAIT);

    // Power-up delay counter: counts once after reset, then stays ready.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wait_cnt  <= '0;
            pwr_ready <= 1'b0;
        end else if (!pwr_ready) begin
            wait_cnt <= wait_cnt + 1'b1;
            if (pwr_fire) pwr_ready <= 1'b1;
        end
    end

    a_r10_fire_once: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_fire |=> (pwr_ready && !pwr_fire));

    a_r1_slot_marks_distinct: assert property (@(posedge clk) disable iff (!rst_n)
        slot_end |-> !(sample_now || load_now));

endmodule

// File: rtl/pld_pe_sync.sv
`timescale 1ns/1ps
// Program-enable conditioner: two-stage synchroniser plus edge and level
// detection. Assumes prog_en is asynchronous and rests high.
module pld_pe_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic prog_en,
    output logic pe_edge,
    output logic pe_low
);
    logic s1, s2, s3;

    // Synchronise and keep one extra stage for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1 <= 1'b1;
            s2 <= 1'b1;
            s3 <= 1'b1;
        end else begin
            s1 <= prog_en;
            s2 <= s1;
            s3 <= s2;
        end
    end

    assign pe_edge = s2 ^ s3;
    assign pe_low  = ~s2;

    a_r7_edge_follows_change: assert property (@(posedge clk) disable iff (!rst_n)
        pe_edge |-> (pe_low != $past(pe_low)));

endmodule

// File: rtl/pld_sequencer.sv
`timescale 1ns/1ps
// Read sequencer: decides when a read starts and walks word slots, the
// transfer slot and the cyclic gap. Assumes one program clock per slot,
// signalled by slot_end. Edges during a busy sequence are dropped.
module pld_sequencer
    import pld_pkg::*;
#(
    parameter int CYCLE_SLOTS = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             slot_end,
    input  logic             sample_now,
    input  logic             load_now,
    input  logic             pwr_fire,
    input  logic             pwr_ready,
    input  logic             pe_edge,
    input  logic             pe_low,
    output logic [SEL_W-1:0] word_sel,
    output logic             word_oe,
    output logic             mem_en_n,
    output logic             cap_en,
    output logic [SEL_W-1:0] cap_idx,
    output logic             load_en
);
    localparam int GAP_SLOTS = CYCLE_SLOTS - WORDS - 1;
    localparam int GAP_W     = (GAP_SLOTS > 1) ? $clog2(GAP_SLOTS) : 1;
    localparam logic [GAP_W-1:0] GAP_LAST = GAP_W'(GAP_SLOTS - 1);
    localparam logic [SEL_W-1:0] SEL_LAST = SEL_W'(WORDS - 1);

    ldr_state_e       st;
    logic [SEL_W-1:0] slot;
    logic [GAP_W-1:0] gap;
    logic             pend;
    logic             req_now;

    // A start request: an edge or low level once ready, or the power-up timeout.
    assign req_now = (pwr_ready && (pe_edge || pe_low)) || pwr_fire;

    // Sequence state, word index, gap count and pending start request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st   <= ST_IDLE;
            slot <= '0;
            gap  <= '0;
            pend <= 1'b0;
        end else begin
            case (st)
                ST_IDLE: begin
                    if (slot_end && (pend || req_now)) begin
                        st   <= ST_READ;
                        slot <= '0;
                        pend <= 1'b0;
                    end else if (req_now) begin
                        pend <= 1'b1;
                    end
                end
                ST_READ: begin
                    if (slot_end) begin
                        if (slot == SEL_LAST) st <= ST_XFER;
                        else                  slot <= slot + 1'b1;
                    end
                end
                ST_XFER: begin
                    if (slot_end) begin
                        if (pwr_ready && pe_low) begin
                            st  <= ST_GAP;
                            gap <= '0;
                        end else begin
                            st <= ST_IDLE;
                        end
                    end
                end
                ST_GAP: begin
                    if (slot_end) begin
                        if (gap == GAP_LAST) begin
                            if (pe_low) begin
                                st   <= ST_READ;
                                slot <= '0;
                            end else begin
                                st <= ST_IDLE;
                            end
                        end else begin
                            gap <= gap + 1'b1;
                        end
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    // Output decode from the sequence state.
    always_comb begin
        word_oe  = (st == ST_READ);
        word_sel = word_oe ? slot : '0;
        mem_en_n = (st == ST_IDLE);
        cap_en   = word_oe && sample_now;
        cap_idx  = slot;
        load_en  = (st == ST_XFER) && load_now;
    end

    a_r1_word_step: assert property (@(posedge clk) disable iff (!rst_n)
        (word_oe && $past(word_oe) && (word_sel != $past(word_sel)))
            |-> (word_sel == $past(word_sel) + 1'b1));

    a_r1_read_from_zero: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(word_oe) |-> (word_sel == '0));

    a_r2_enable_covers_address: assert property (@(posedge clk) disable iff (!rst_n)
        word_oe |-> !mem_en_n);

    a_r3_capture_in_read: assert property (@(posedge clk) disable iff (!rst_n)
        cap_en |-> (word_oe && !slot_end));

    a_r8_no_pending_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (st != ST_IDLE) |-> !pend);

endmodule

// File: rtl/pld_assembler.sv
`timescale 1ns/1ps
// Field assembler: stores the captured nibbles and, on load, copies the
// mapped fields to the output registers. Assumes cap_idx names the word
// currently addressed. Partial data never reaches the outputs.
module pld_assembler
    import pld_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cap_en,
    input  logic [SEL_W-1:0] cap_idx,
    input  logic [NIB_W-1:0] mem_data,
    input  logic             load_en,
    output logic [REF_W-1:0] ref_div,
    output logic [M_W-1:0]   m_count,
    output logic [A_W-1:0]   a_count,
    output logic             load_stb
);
    logic [NIB_W-1:0]  nib_q [WORDS];
    logic [FLAT_W-1:0] nib_flat;
    chan_fields_t      fields;

    // Nibble store: capture the addressed word at its sample point.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int w = 0; w < WORDS; w++) nib_q[w] <= '0;
        end else begin
            for (int w = 0; w < WORDS; w++) begin
                if (cap_en && (cap_idx == SEL_W'(w))) nib_q[w] <= mem_data;
            end
        end
    end

    for (genvar g = 0; g < WORDS; g++) begin : g_flat
        assign nib_flat[g*NIB_W +: NIB_W] = nib_q[g];
    end

    assign fields = assemble_fields(nib_flat);

    // Output registers and strobe: updated together in the transfer cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_div  <= '0;
            m_count  <= '0;
            a_count  <= '0;
            load_stb <= 1'b0;
        end else begin
            load_stb <= load_en;
            if (load_en) begin
                ref_div <= fields.ref_div;
                m_count <= fields.m_val;
                a_count <= fields.a_val;
            end
        end
    end

    a_r6_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
        load_stb |=> !load_stb);

    a_r6_fields_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !load_stb |-> ($stable(ref_div) && $stable(m_count) && $stable(a_count)));

endmodule

// File: rtl/prom_loader.sv
`timescale 1ns/1ps
// Top: channel data loader. Connects the timebase, program-enable
// conditioner, read sequencer and field assembler. Assumes clk is the
// reference clock and that reset release marks power-up detection.
module prom_loader
    import pld_pkg::*;
#(
    parameter int PRESC_BITS     = 6,
    parameter int SAMPLE_POINT   = 60,
    parameter int POWERUP_CYCLES = 53248,
    parameter int CYCLE_SLOTS    = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             prog_en,
    input  logic [NIB_W-1:0] mem_data,
    output logic [SEL_W-1:0] word_sel,
    output logic             word_sel_oe,
    output logic             mem_en_n,
    output logic [REF_W-1:0] ref_div,
    output logic [M_W-1:0]   m_count,
    output logic [A_W-1:0]   a_count,
    output logic             load_stb
);
    logic             slot_end, sample_now, load_now;
    logic             pwr_fire, pwr_ready;
    logic             pe_edge, pe_low;
    logic             cap_en, load_en;
    logic [SEL_W-1:0] cap_idx;

    pld_timebase #(
        .PRESC_BITS    (PRESC_BITS),
        .SAMPLE_POINT  (SAMPLE_POINT),
        .POWERUP_CYCLES(POWERUP_CYCLES)
    ) u_timebase (
        .clk       (clk),
        .rst_n     (rst_n),
        .slot_end  (slot_end),
        .sample_now(sample_now),
        .load_now  (load_now),
        .pwr_fire  (pwr_fire),
        .pwr_ready (pwr_ready)
    );

    pld_pe_sync u_pe_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .prog_en(prog_en),
        .pe_edge(pe_edge),
        .pe_low (pe_low)
    );

    pld_sequencer #(
        .CYCLE_SLOTS(CYCLE_SLOTS)
    ) u_sequencer (
        .clk       (clk),
        .rst_n     (rst_n),
        .slot_end  (slot_end),
        .sample_now(sample_now),
        .load_now  (load_now),
        .pwr_fire  (pwr_fire),
        .pwr_ready (pwr_ready),
        .pe_edge   (pe_edge),
        .pe_low    (pe_low),
        .word_sel  (word_sel),
        .word_oe   (word_sel_oe),
        .mem_en_n  (mem_en_n),
        .cap_en    (cap_en),
        .cap_idx   (cap_idx),
        .load_en   (load_en)
    );

    pld_assembler u_assembler (
        .clk     (clk),
        .rst_n   (rst_n),
        .cap_en  (cap_en),
        .cap_idx (cap_idx),
        .mem_data(mem_data),
        .load_en (load_en),
        .ref_div (ref_div),
        .m_count (m_count),
        .a_count (a_count),
        .load_stb(load_stb)
    );

    a_r11_strobe_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        load_stb |-> !mem_en_n);

endmodule

// File: tb/prom_loader_tb.sv
`timescale 1ns/1ps
// Bench: behavioural memory and cycle-by-cycle reference model, compared
// on every falling clock edge, plus directed checks per requirement.
module prom_loader_tb;
    localparam int DELAY = 53248;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        prog_en;
    logic [3:0]  mem_data;
    logic [2:0]  word_sel;
    logic        word_sel_oe, mem_en_n, load_stb;
    logic [10:0] ref_div;
    logic [9:0]  m_count;
    logic [6:0]  a_count;

    logic [3:0]  mem [8];
    logic [3:0]  glitch = 4'h0;
    logic        glitch_en = 1'b0;
    logic [7:0]  lfsr = 8'h5A;

    int nvec = 0, nfail = 0, cyc = 0;
    int me_falls = 0, fall_cyc = 0, me_high_cnt = 0;
    logic prev_me = 1'b1;
    bit model_on = 0;

    always #10 clk = ~clk;

    assign mem_data = word_sel_oe ? (mem[word_sel] ^ glitch) : 4'hF;

    prom_loader u_dut (
        .clk(clk), .rst_n(rst_n), .prog_en(prog_en), .mem_data(mem_data),
        .word_sel(word_sel), .word_sel_oe(word_sel_oe), .mem_en_n(mem_en_n),
        .ref_div(ref_div), .m_count(m_count), .a_count(a_count), .load_stb(load_stb)
    );

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        nvec++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    endtask

    // ---------------- reference model ----------------
    int pc, s1, s2, s3, wc, rdy, pend, st, slot, gc;
    logic [3:0]  mn [8];
    logic [10:0] er;
    logic [9:0]  em;
    logic [6:0]  ea;
    logic        estb;

    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000) begin
            nfail++;
            $display("FAIL watchdog: actual %0d expected below %0d", cyc, 190000);
            finish_run();
        end
        if (!rst_n) begin
            pc = 0; s1 = 1; s2 = 1; s3 = 1; wc = 0; rdy = 0; pend = 0;
            st = 0; slot = 0; gc = 0; estb = 0; er = '0; em = '0; ea = '0;
            for (int i = 0; i < 8; i++) mn[i] = 4'h0;
            model_on = 1;
        end else begin
            bit edge_s, low_s, fire, req, wrap;
            int st_n, slot_n, gc_n, pend_n;
            edge_s = (s2 != s3);
            low_s  = (s2 == 0);
            fire   = (rdy == 0) && (wc == DELAY - 1);
            req    = (rdy != 0 && (edge_s || low_s)) || fire;
            wrap   = (pc == 63);
            st_n = st; slot_n = slot; gc_n = gc; pend_n = pend;
            estb = 0;
            case (st)
                0: if (wrap && (pend != 0 || req)) begin st_n = 1; slot_n = 0; pend_n = 0; end
                   else if (req) pend_n = 1;
                1: begin
                    if (pc == 60) mn[slot] = mem[slot] ^ glitch;
                    if (wrap) begin
                        if (slot == 7) st_n = 2; else slot_n = slot + 1;
                    end
                end
                2: begin
                    if (pc == 31) begin
                        em = {mn[2], mn[1], mn[0][3:2]};
                        ea = {mn[4][2:0], mn[3]};
                        er = {mn[7][2:0], mn[6], mn[5]};
                        estb = 1;
                    end
                    if (wrap) begin
                        if (rdy != 0 && low_s) begin st_n = 3; gc_n = 0; end else st_n = 0;
                    end
                end
                default: if (wrap) begin
                    if (gc == 6) begin
                        if (low_s) begin st_n = 1; slot_n = 0; end else st_n = 0;
                    end else gc_n = gc + 1;
                end
            endcase
            st = st_n; slot = slot_n; gc = gc_n; pend = pend_n;
            pc = (pc + 1) % 64;
            s3 = s2; s2 = s1; s1 = int'(prog_en);
            if (rdy == 0) begin wc++; if (fire) rdy = 1; end
        end
    end

    // Per-clock comparison against the model, plus enable-edge tracking.
    always @(negedge clk) begin
        if (model_on) begin
            string t;
            t = rst_n ? "R2" : "R11";
            chk(t, "mem_en_n", mem_en_n, (st == 0));
            t = rst_n ? "R1" : "R11";
            chk(t, "word_sel_oe", word_sel_oe, (st == 1));
            chk(t, "word_sel", word_sel, (st == 1) ? slot : 0);
            t = rst_n ? "R6" : "R11";
            chk(t, "load_stb", load_stb, estb);
            t = rst_n ? "R4" : "R11";
            chk(t, "ref_div", ref_div, er);
            chk(t, "m_count", m_count, em);
            chk(t, "a_count", a_count, ea);
        end
        if (prev_me && !mem_en_n) begin me_falls++; fall_cyc = cyc; end
        if (mem_en_n) me_high_cnt++;
        prev_me = mem_en_n;
        if (glitch_en) begin
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            glitch = lfsr[3:0];
        end else glitch = 4'h0;
    end

    // ---------------- stimulus ----------------
    task automatic set_mem(input int k);
        for (int w = 0; w < 8; w++) mem[w] = 4'((k * 7 + w * 11 + 5) ^ (k * 3));
        if (k == 1) for (int w = 0; w < 8; w++) mem[w] = 4'hF;
        if (k == 2) for (int w = 0; w < 8; w++) mem[w] = 4'h0;
    endtask

    task automatic pulse(input int w);
        @(negedge clk); prog_en = 1'b0;
        repeat (w) @(negedge clk);
        prog_en = 1'b1;
    endtask

    task automatic wait_strobe();
        @(negedge clk);
        while (!load_stb) @(negedge clk);
    endtask

    task automatic check_direct(input string tag);
        chk(tag, "m_count direct", m_count, {mem[2], mem[1], mem[0][3:2]});
        chk(tag, "a_count direct", a_count, {mem[4][2:0], mem[3]});
        chk(tag, "ref_div direct", ref_div, {mem[7][2:0], mem[6], mem[5]});
    endtask

    initial begin
        int rel, t0, f0, lat;
        logic [10:0] sr; logic [9:0] sm; logic [6:0] sa;
        prog_en = 1'b1; rst_n = 1'b0; set_mem(3);
        repeat (4) @(negedge clk);
        chk("R11", "reset mem_en_n", mem_en_n, 1);
        chk("R11", "reset oe", word_sel_oe, 0);
        chk("R11", "reset stb", load_stb, 0);
        chk("R11", "reset ref_div", ref_div, 0);
        rst_n = 1'b1; rel = cyc;

        // R10: pulse during the power-up wait is ignored.
        repeat (1000) @(negedge clk);
        pulse(4);
        repeat (1000) @(negedge clk);
        chk("R10", "no early read", me_falls, 0);
        wait_strobe();
        lat = fall_cyc - rel;
        chk("R10", "power-up start window", (lat >= DELAY && lat <= DELAY + 64), 1);
        check_direct("R4");

        // R7 and R4: single shots at stepped prescaler phases.
        for (int i = 0; i < 6; i++) begin
            set_mem(i + 1);
            repeat (100 + (i * 13) % 64) @(negedge clk);
            f0 = me_falls; t0 = cyc + 1;
            pulse((i % 4) + 1);
            while (me_falls == f0) @(negedge clk);
            lat = fall_cyc - t0;
            chk("R7", "start latency", (lat >= 3 && lat <= 66), 1);
            wait_strobe();
            check_direct("R4");
        end

        // R5: ignored bits have no effect.
        set_mem(9);
        repeat (50) @(negedge clk);
        pulse(2); wait_strobe();
        sr = ref_div; sm = m_count; sa = a_count;
        mem[0] = mem[0] ^ 4'h3; mem[4] = mem[4] ^ 4'h8; mem[7] = mem[7] ^ 4'h8;
        repeat (100) @(negedge clk);
        pulse(2); wait_strobe();
        chk("R5", "ref_div unchanged", ref_div, sr);
        chk("R5", "m_count unchanged", m_count, sm);
        chk("R5", "a_count unchanged", a_count, sa);

        // R8: edges during a read start nothing further.
        set_mem(10);
        repeat (77) @(negedge clk);
        f0 = me_falls;
        pulse(2);
        while (me_falls == f0) @(negedge clk);
        repeat (300) @(negedge clk);
        pulse(3);
        wait_strobe();
        pulse(1);
        repeat (1500) @(negedge clk);
        chk("R8", "single read only", me_falls, f0 + 1);
        check_direct("R4");

        // R3: data toggles every cycle; only the sample point counts.
        set_mem(11);
        repeat (40) @(negedge clk);
        glitch_en = 1'b1;
        pulse(2); wait_strobe();
        glitch_en = 1'b0;
        chk("R3", "ref_div at sample point", ref_div, er);
        chk("R3", "m_count at sample point", m_count, em);
        chk("R3", "a_count at sample point", a_count, ea);

        // R9: cyclic mode.
        set_mem(12);
        repeat (30) @(negedge clk);
        prog_en = 1'b0;
        wait_strobe();
        me_high_cnt = 0;
        t0 = cyc;
        wait_strobe();
        chk("R9", "cyclic period", cyc - t0, 1024);
        set_mem(13);
        t0 = cyc;
        wait_strobe();
        chk("R9", "cyclic period", cyc - t0, 1024);
        check_direct("R9");
        chk("R9", "enable held low", me_high_cnt, 0);
        prog_en = 1'b1;
        repeat (2000) @(negedge clk);
        chk("R9", "released after cyclic", mem_en_n, 1);

        finish_run();
    end

endmodule